// File: doc/BRIEF.md
# Shared-Bus Block Supplier Resolver

On a bus with one shared transfer path, many private caches and one main memory, a read request for a block must be answered by exactly one agent. This block makes that decision. It looks at the snoop result of every cache, one hit flag and one modified flag per cache. When at least one cache holds the block, it grants exactly one of them the right to drive the data. A fixed ripple priority chain makes the choice, and cache 0 has the highest priority. In that case it also inhibits main memory. When no cache holds the block, memory supplies it.

The requester learns through a from-cache flag whether the data came from another cache or from memory. It uses this to pick the Shared or the Exclusive state for its fill. On a plain read where the chosen cache holds the block modified, memory is told to capture the block from the bus during the same transfer. A read that also invalidates other copies uses the same selection but never asks memory to capture.

The decision is registered in the cycle after the request is accepted. It then stays frozen for a transfer of `XFER_CYCLES` bus cycles. A busy flag covers the whole transfer and a one-cycle done pulse marks its last cycle.

Top module: `snoop_supplier_resolver`

## Requirements
- R1: When one or more caches report a hit, exactly one grant bit is high during the transfer: the hitting cache with the lowest index (bit i of the grant vector belongs to cache i).
- R2: The memory inhibit output is high during a transfer exactly when some cache hit at the time of the request.
- R3: When no cache hits, no grant bit is high and the memory inhibit is low for the whole transfer, so memory supplies the block.
- R4: The from-cache output is high during a transfer exactly when the block is supplied by a cache.
- R5: On a plain read (kind input 0), the memory write-enable is high during the transfer exactly when the granted cache reports its block as modified.
- R6: On a read-with-invalidate request (kind input 1), the memory write-enable stays low even when the granted cache holds modified data.
- R7: Modified flags of caches that did not win, and modified flags of caches that did not hit, do not affect the memory write-enable.
- R8: A request is accepted at a clock edge where the block is idle. The busy output is then high for exactly `XFER_CYCLES` cycles starting with the next cycle, and the done output is high only in the last of those cycles.
- R9: Grants, inhibit, from-cache and write-enable hold their values for the whole transfer, even if the hit, modified or kind inputs change after the request is accepted.
- R10: A request presented while busy is high is ignored. A request held high is accepted at the first edge after the busy output falls.
- R11: While reset is high, and in the first cycle after it, all outputs are low.
- R12: While busy is low, all grant bits, the inhibit, the from-cache flag and the write-enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | A read request is on the bus this cycle |
| req_inv_i | input | 1 | Request kind: 0 plain read, 1 read with invalidate |
| snoop_hit_i | input | N_CACHES | Per-cache snoop hit, bit i for cache i |
| snoop_dirty_i | input | N_CACHES | Per-cache modified flag for the snooped block |
| supply_grant_o | output | N_CACHES | One-hot grant to the cache that drives the block |
| mem_inhibit_o | output | 1 | Keeps main memory off the data bus |
| mem_wr_en_o | output | 1 | Memory captures the block from the bus during the transfer |
| from_cache_o | output | 1 | The block comes from a cache (requester fills it Shared) |
| xfer_busy_o | output | 1 | A transfer is in progress |
| xfer_done_o | output | 1 | Last cycle of the transfer |

## Verification
Single-hit patterns on each cache show that every chain position can win, and multi-hit patterns such as 1010, 1100 and 1111 show that the lowest index wins over all others. Hit-free requests with modified flags set show that memory supplies and that stray modified flags are ignored. Dirty winners and dirty losers under both request kinds separate the write-back condition from the invalidate override. Changing inputs and held requests during a transfer show the frozen decision, the ignored requests and the back-to-back acceptance right after done. A long pseudo-random stream then mixes all of these cases.

// File: rtl/snp_pkg.sv
package snp_pkg;

  typedef enum logic {
    KIND_READ     = 1'b0,
    KIND_READ_INV = 1'b1
  } req_kind_e;

  // Decision captured at request acceptance
  typedef struct packed {
    logic any_hit;
    logic wb_needed;
  } supply_flags_t;

endpackage

// File: rtl/snp_prio_chain.sv
module snp_prio_chain #(
  parameter int N_CACHES = 4
) (
  input  logic [N_CACHES-1:0] hit_i,
  input  logic [N_CACHES-1:0] dirty_i,
  output logic [N_CACHES-1:0] grant_o,
  output logic                any_hit_o,
  output logic                winner_dirty_o
);

  // enable token ripples from cache 0 downward, stopped by the first hit
  logic [N_CACHES:0] token;
  assign token[0] = 1'b1;

  genvar g;
  generate
    for (g = 0; g < N_CACHES; g++) begin : g_link
      assign grant_o[g]   = hit_i[g] & token[g];
      assign token[g+1]   = token[g] & ~hit_i[g];
    end
  endgenerate

  assign any_hit_o      = ~token[N_CACHES];
  assign winner_dirty_o = |(grant_o & dirty_i);

  always_comb begin
    assert_grant_onehot_R1: assert ($onehot0(grant_o));
    assert_grant_in_hits_R1: assert ((grant_o & ~hit_i) == '0);
  end

endmodule

// File: rtl/snp_xfer_timer.sv
module snp_xfer_timer #(
  parameter int XFER_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);

  localparam int CNT_W = $clog2(XFER_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(XFER_CYCLES);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end else if (start_i) begin
      remain_q <= LOAD;
    end
  end

  assign busy_o = (remain_q != '0);
  assign done_o = (remain_q == CNT_W'(1));

  assert_start_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);
  assert_done_ends_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !busy_o);
  assert_remain_bound_R8: assert property (@(posedge clk) disable iff (rst)
    remain_q <= LOAD);

endmodule

// File: rtl/snoop_supplier_resolver.sv
module snoop_supplier_resolver #(
  parameter int N_CACHES    = 4,
  parameter int XFER_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid_i,
  input  logic                req_inv_i,
  input  logic [N_CACHES-1:0] snoop_hit_i,
  input  logic [N_CACHES-1:0] snoop_dirty_i,
  output logic [N_CACHES-1:0] supply_grant_o,
  output logic                mem_inhibit_o,
  output logic                mem_wr_en_o,
  output logic                from_cache_o,
  output logic                xfer_busy_o,
  output logic                xfer_done_o
);
  import snp_pkg::*;

  logic [N_CACHES-1:0] chain_grant;
  logic                chain_any;
  logic                chain_dirty;
  logic                accept;
  req_kind_e           kind;
  req_kind_e           kind_q;
  supply_flags_t       flags_d;
  supply_flags_t       flags_q;
  logic [N_CACHES-1:0] grant_q;

  snp_prio_chain #(.N_CACHES(N_CACHES)) u_chain (
    .hit_i          (snoop_hit_i),
    .dirty_i        (snoop_dirty_i),
    .grant_o        (chain_grant),
    .any_hit_o      (chain_any),
    .winner_dirty_o (chain_dirty)
  );

  snp_xfer_timer #(.XFER_CYCLES(XFER_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start_i (accept),
    .busy_o  (xfer_busy_o),
    .done_o  (xfer_done_o)
  );

  assign accept = req_valid_i && !xfer_busy_o;
  assign kind   = req_inv_i ? KIND_READ_INV : KIND_READ;

  always_comb begin
    flags_d.any_hit   = chain_any;
    flags_d.wb_needed = chain_dirty && (kind == KIND_READ);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      flags_q <= '0;
      kind_q  <= KIND_READ;
    end else if (accept) begin
      grant_q <= chain_grant;
      flags_q <= flags_d;
      kind_q  <= kind;
    end else if (xfer_done_o) begin
      grant_q <= '0;
      flags_q <= '0;
      kind_q  <= KIND_READ;
    end
  end

  assign supply_grant_o = grant_q;
  assign mem_inhibit_o  = flags_q.any_hit;
  assign from_cache_o   = flags_q.any_hit;
  assign mem_wr_en_o    = flags_q.wb_needed;

  assert_inhibit_has_grant_R2: assert property (@(posedge clk) disable iff (rst)
    mem_inhibit_o |-> $onehot(supply_grant_o));
  assert_no_inhibit_no_grant_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_inhibit_o |-> (supply_grant_o == '0));
  assert_wb_needs_cache_R5: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en_o |-> (mem_inhibit_o && from_cache_o));
  assert_inv_no_wb_R6: assert property (@(posedge clk) disable iff (rst)
    (kind_q == KIND_READ_INV) |-> !mem_wr_en_o);
  assert_hold_grant_R9: assert property (@(posedge clk) disable iff (rst)
    (xfer_busy_o && !xfer_done_o) |=> ($stable(supply_grant_o) && $stable(mem_wr_en_o)));
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !xfer_busy_o |-> (supply_grant_o == '0 && !mem_inhibit_o && !mem_wr_en_o && !from_cache_o));

endmodule

// File: tb/snoop_supplier_resolver_tb.sv
module snoop_supplier_resolver_tb;

  localparam int N  = 4;
  localparam int XC = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_inv = 1'b0;
  logic [N-1:0] hit = '0;
  logic [N-1:0] dirty = '0;
  logic [N-1:0] grant;
  logic         inhibit, wr_en, from_cache, busy, done;

  always #2.5 clk = ~clk;

  snoop_supplier_resolver #(.N_CACHES(N), .XFER_CYCLES(XC)) u_dut (
    .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_inv_i(req_inv),
    .snoop_hit_i(hit), .snoop_dirty_i(dirty), .supply_grant_o(grant),
    .mem_inhibit_o(inhibit), .mem_wr_en_o(wr_en), .from_cache_o(from_cache),
    .xfer_busy_o(busy), .xfer_done_o(done)
  );

  // behavioural reference
  int     rem = 0;
  int     e_grant = 0;
  bit     e_any = 0, e_wr = 0, e_inv = 0;
  bit     post_reset = 0;
  int     n_cmp = 0, n_bad = 0, cycles = 0;
  string  scen = "";
  bit     finished = 0;

  always @(posedge clk) begin
    post_reset = rst;
    if (rst) begin
      rem = 0; e_grant = 0; e_any = 0; e_wr = 0; e_inv = 0;
    end else if (rem > 0) begin
      rem--;
      if (rem == 0) begin e_grant = 0; e_any = 0; e_wr = 0; e_inv = 0; end
    end else if (req_valid) begin
      int w;
      w = -1;
      for (int i = N - 1; i >= 0; i--) if (hit[i]) w = i;
      rem = XC;
      e_inv = req_inv;
      if (w >= 0) begin
        e_grant = 1 << w; e_any = 1; e_wr = dirty[w] && !req_inv;
      end else begin
        e_grant = 0; e_any = 0; e_wr = 0;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at t=%0t", tag, scen, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst || post_reset) begin
      chk("R11", int'(grant), 0);   chk("R11", int'(inhibit), 0);
      chk("R11", int'(wr_en), 0);   chk("R11", int'(from_cache), 0);
      chk("R11", int'(busy), 0);    chk("R11", int'(done), 0);
    end else if (rem == 0) begin
      chk("R12", int'(grant), 0);   chk("R12", int'(inhibit), 0);
      chk("R12", int'(wr_en), 0);   chk("R12", int'(from_cache), 0);
      chk("R8", int'(busy), 0);     chk("R8", int'(done), 0);
    end else begin
      chk(e_any ? "R1" : "R3", int'(grant), e_grant);
      chk("R2", int'(inhibit), int'(e_any));
      chk("R4", int'(from_cache), int'(e_any));
      chk(e_inv ? "R6" : "R5", int'(wr_en), int'(e_wr));
      chk("R8", int'(busy), 1);
      chk("R8", int'(done), int'(rem == 1));
    end
  end

  // one request, then idle until the transfer is over
  task automatic one_req(string tag, bit inv, logic [N-1:0] h, logic [N-1:0] d);
    scen = tag;
    req_valid = 1'b1; req_inv = inv; hit = h; dirty = d;
    @(negedge clk);
    req_valid = 1'b0; hit = '0; dirty = '0; req_inv = 1'b0;
    repeat (XC + 1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);

    // R1/R4 single hits, every chain position
    for (int i = 0; i < N; i++) one_req("R1_single", 0, 4'(1 << i), '0);
    // R1 several hits
    one_req("R1_multi", 0, 4'b1010, '0);
    one_req("R1_multi", 0, 4'b1100, '0);
    one_req("R1_multi", 0, 4'b1111, '0);
    // R3 no hit, stray modified flags
    one_req("R3_memory", 0, 4'b0000, 4'b1111);
    // R5 dirty winner
    one_req("R5_dirty", 0, 4'b0110, 4'b0010);
    // R7 dirty loser only
    one_req("R7_loser", 0, 4'b0110, 4'b1100);
    one_req("R7_loser", 0, 4'b0001, 4'b1110);
    // R6 invalidate with dirty winner
    one_req("R6_inv", 1, 4'b0100, 4'b0100);
    one_req("R6_inv", 1, 4'b0000, 4'b1111);

    // R9/R10 inputs change and request held during transfer
    scen = "R9_hold";
    req_valid = 1'b1; req_inv = 1'b0; hit = 4'b1000; dirty = 4'b1000;
    @(negedge clk);
    hit = 4'b0001; dirty = 4'b0000; req_inv = 1'b1;
    scen = "R10_busy";
    repeat (XC) @(negedge clk);
    // R10 held request accepted right after done
    hit = 4'b0011; dirty = 4'b0001; req_inv = 1'b0;
    @(negedge clk);
    req_valid = 1'b0; hit = '0; dirty = '0;
    repeat (XC + 1) @(negedge clk);

    // mixed stream
    scen = "mixed";
    for (int k = 0; k < 400; k++) begin
      req_valid = ($urandom_range(0, 3) != 0);
      req_inv   = $urandom_range(0, 1);
      hit       = 4'($urandom_range(0, 15));
      dirty     = 4'($urandom_range(0, 15));
      @(negedge clk);
    end
    req_valid = 1'b0;
    repeat (XC + 2) @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule